// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast Vectors

This block sits between a set of peripheral interrupt request lines and a small signal-processing core. Each request line is captured into a pending bit. Software gives each line a 2-bit priority level and an enable. On every cycle the block picks one pending, enabled request that the core's current 2-bit mask allows. The winner is the request with the highest level, and among requests at that level the one with the lowest vector number. The block then presents the winner's vector number, its level, a status code and a 21-bit handler address to the core.

Handler addresses normally come from a programmable base register: the base is shifted left by five and twice the vector number is added. Two match registers hold vector numbers for fast handling. When the winning request is at level 2 and its vector equals one of these registers, the block marks it as fast. It then presents an absolute address held in a low/high register pair, and the base is not used.

The core clears a pending bit by pulsing an acknowledge together with that vector number. Configuration goes through a simple write-only port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with nothing yet configured, every output is zero and every source is disabled.
- R2: Priority words sit at register addresses 0 to NUM_SRC/4-1. Source s uses word s/4, nibble k=s%4. Bit 4k+2 is the enable and bits 4k+1:4k are the level. A source whose enable is 0 is never presented, even when its request is pending.
- R3: A high request line sets its pending bit at the clock edge. A pulse on ack_valid with ack_vec equal to v clears pending bit v. If a request and a clear for the same source arrive in the same cycle, the bit stays set.
- R4: A pending, enabled source may be presented only if its level is greater than or equal to core_mask. So mask 00 accepts levels 0-3, 01 accepts 1-3, 10 accepts 2-3, and 11 accepts only level 3.
- R5: Among the presentable sources, the highest level wins. Among sources at that level, the lowest vector number (the source index) wins.
- R6: The outputs are registered. A request that is high at edge n becomes pending at edge n, and the outputs show it from edge n+1.
- R7: pres_level is 00 when nothing is presented, 01 for level 0, 10 for level 1, and 11 for level 2 or 3.
- R8: The base register is at address 0x10. For a normal interrupt, irq_addr = (base << 5) + 2*vector, truncated to 21 bits.
- R9: Match registers are at 0x11 and 0x12 and use the low VEC_W bits. Address pair 0 is low 0x13 and high 0x14 (bits 4:0); pair 1 is low 0x15 and high 0x16. A winner at level 2 whose vector equals a match register gets irq_fast=1 and irq_addr={high,low}. A winner at any other level gets irq_fast=0 and the normal address.
- R10: When both match registers equal a level-2 winner's vector, pair 0 supplies the address.
- R11: When no source is presentable, irq_valid, irq_vec, irq_lvl, irq_fast and irq_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| irq_req | input | NUM_SRC | Interrupt request lines, one per vector |
| core_mask | input | 2 | Core's current interrupt mask |
| ack_valid | input | 1 | Acknowledge pulse from the core |
| ack_vec | input | VEC_W | Vector being acknowledged |
| irq_valid | output | 1 | A request is being presented |
| irq_vec | output | VEC_W | Presented vector number |
| irq_lvl | output | 2 | Presented priority level |
| irq_fast | output | 1 | Presented request takes a fast handler address |
| irq_addr | output | 21 | Handler address |
| pres_level | output | 2 | Status code of the presented level |

## Verification
The bench goes after ties at one level. An arbiter that favours the highest index, or the most recent request, would present the wrong vector. It checks a level-3 request under mask 11, and a level-1 request under mask 10. An off-by-one in the mask compare would either drop the first or present the second. For fast handling it checks a level-3 request whose vector matches a match register, which must fall back to the base address, and two match registers that hold the same vector, where a design that let pair 1 win would return the wrong address. It also checks an acknowledge that lands together with a new request for the same line; a design with clear priority would lose that request.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 21;
  localparam int HI_W       = ADDR_W - DATA_W;
  localparam int LVL_W      = 2;
  localparam int BASE_SHIFT = 5;
  localparam int REG_AW     = 5;
  localparam int SRC_PER_WD = 4;
  localparam int FIELD_W    = DATA_W / SRC_PER_WD;
  localparam int EN_BIT     = 2;

  localparam logic [LVL_W-1:0] FAST_LVL = 2'd2;

  localparam logic [REG_AW-1:0] A_BASE   = 5'h10;
  localparam logic [REG_AW-1:0] A_MATCH0 = 5'h11;
  localparam logic [REG_AW-1:0] A_MATCH1 = 5'h12;
  localparam logic [REG_AW-1:0] A_LO0    = 5'h13;
  localparam logic [REG_AW-1:0] A_HI0    = 5'h14;
  localparam logic [REG_AW-1:0] A_LO1    = 5'h15;
  localparam logic [REG_AW-1:0] A_HI1    = 5'h16;

  typedef logic [LVL_W-1:0] lvl_t;

  function automatic logic [1:0] status_of(input lvl_t lvl);
    case (lvl)
      2'd0:    return 2'b01;
      2'd1:    return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [REG_AW-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [NUM_SRC-1:0]            src_en,
  output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
  output logic [DATA_W-1:0]             base,
  output logic [1:0][VEC_W-1:0]         match,
  output logic [1:0][DATA_W-1:0]        addr_lo,
  output logic [1:0][HI_W-1:0]          addr_hi
);

  localparam int PRIO_WORDS = (NUM_SRC + SRC_PER_WD - 1) / SRC_PER_WD;

  logic [PRIO_WORDS-1:0][DATA_W-1:0] prio_q, prio_d;
  logic [DATA_W-1:0]                 base_q, base_d;
  logic [1:0][VEC_W-1:0]             match_q, match_d;
  logic [1:0][DATA_W-1:0]            lo_q, lo_d;
  logic [1:0][HI_W-1:0]              hi_q, hi_d;

  always_comb begin
    prio_d  = prio_q;
    base_d  = base_q;
    match_d = match_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (cfg_we) begin
      for (int w = 0; w < PRIO_WORDS; w++) begin
        if (cfg_addr == REG_AW'(w)) prio_d[w] = cfg_wdata;
      end
      case (cfg_addr)
        A_BASE:   base_d     = cfg_wdata;
        A_MATCH0: match_d[0] = cfg_wdata[VEC_W-1:0];
        A_MATCH1: match_d[1] = cfg_wdata[VEC_W-1:0];
        A_LO0:    lo_d[0]    = cfg_wdata;
        A_HI0:    hi_d[0]    = cfg_wdata[HI_W-1:0];
        A_LO1:    lo_d[1]    = cfg_wdata;
        A_HI1:    hi_d[1]    = cfg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      base_q  <= '0;
      match_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (cfg_we) begin
      prio_q  <= prio_d;
      base_q  <= base_d;
      match_q <= match_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_en[s]  = prio_q[s/SRC_PER_WD][FIELD_W*(s%SRC_PER_WD) + EN_BIT];
    assign src_lvl[s] = prio_q[s/SRC_PER_WD][FIELD_W*(s%SRC_PER_WD) +: LVL_W];
  end

  assign base    = base_q;
  assign match   = match_q;
  assign addr_lo = lo_q;
  assign addr_hi = hi_q;

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               ack_valid,
  input  logic [VEC_W-1:0]   ack_vec,
  output logic [NUM_SRC-1:0] pend
);

  logic [NUM_SRC-1:0] pend_q, pend_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr;
    assign clr       = ack_valid && (ack_vec == VEC_W'(i));
    assign pend_d[i] = req[i] | (pend_q[i] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !req[ack_vec]) |=> !pend_q[$past(ack_vec)]);

  // R3
  req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> ((pend_q & $past(req)) == $past(req)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 4
) (
  input  logic [NUM_SRC-1:0]            pend,
  input  logic [NUM_SRC-1:0]            src_en,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
  input  logic [LVL_W-1:0]              core_mask,
  output logic                          found,
  output logic [VEC_W-1:0]              win_vec,
  output logic [LVL_W-1:0]              win_lvl
);

  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pend[i] && src_en[i] && (src_lvl[i] >= core_mask);
  end

  // Scan from the top index down so that, among equal levels, the lowest
  // index overwrites last and wins.
  always_comb begin
    found   = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!found || (src_lvl[i] >= win_lvl))) begin
        found   = 1'b1;
        win_vec = VEC_W'(i);
        win_lvl = src_lvl[i];
      end
    end
  end

endmodule

// File: rtl/irq_vector_out.sv
module irq_vector_out
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   found,
  input  logic [VEC_W-1:0]       win_vec,
  input  logic [LVL_W-1:0]       win_lvl,
  input  logic [DATA_W-1:0]      base,
  input  logic [1:0][VEC_W-1:0]  match,
  input  logic [1:0][DATA_W-1:0] addr_lo,
  input  logic [1:0][HI_W-1:0]   addr_hi,
  output logic                   irq_valid,
  output logic [VEC_W-1:0]       irq_vec,
  output logic [LVL_W-1:0]       irq_lvl,
  output logic                   irq_fast,
  output logic [ADDR_W-1:0]      irq_addr,
  output logic [1:0]             pres_level
);

  logic              hit0, hit1;
  logic [ADDR_W-1:0] norm_addr;

  logic              valid_d, valid_q;
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic [LVL_W-1:0]  lvl_d, lvl_q;
  logic              fast_d, fast_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [1:0]        stat_d, stat_q;

  always_comb begin
    hit0      = (win_lvl == FAST_LVL) && (win_vec == match[0]);
    hit1      = (win_lvl == FAST_LVL) && (win_vec == match[1]);
    norm_addr = (ADDR_W'(base) << BASE_SHIFT) + ADDR_W'({win_vec, 1'b0});
    valid_d   = 1'b0;
    vec_d     = '0;
    lvl_d     = '0;
    fast_d    = 1'b0;
    addr_d    = '0;
    stat_d    = 2'b00;
    if (found) begin
      valid_d = 1'b1;
      vec_d   = win_vec;
      lvl_d   = win_lvl;
      fast_d  = hit0 | hit1;
      stat_d  = status_of(win_lvl);
      if (hit0)      addr_d = {addr_hi[0], addr_lo[0]};
      else if (hit1) addr_d = {addr_hi[1], addr_lo[1]};
      else           addr_d = norm_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= '0;
      fast_q  <= 1'b0;
      addr_q  <= '0;
      stat_q  <= 2'b00;
    end else begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
      lvl_q   <= lvl_d;
      fast_q  <= fast_d;
      addr_q  <= addr_d;
      stat_q  <= stat_d;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vec    = vec_q;
  assign irq_lvl    = lvl_q;
  assign irq_fast   = fast_q;
  assign irq_addr   = addr_q;
  assign pres_level = stat_q;

  // R9
  fast_only_lvl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> (irq_valid && irq_lvl == FAST_LVL));

  // R7
  status_matches_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_level != 2'b00) == irq_valid);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter  int NUM_SRC = 16,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [4:0]         cfg_addr,
  input  logic [15:0]        cfg_wdata,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [1:0]         core_mask,
  input  logic               ack_valid,
  input  logic [VEC_W-1:0]   ack_vec,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [1:0]         irq_lvl,
  output logic               irq_fast,
  output logic [20:0]        irq_addr,
  output logic [1:0]         pres_level
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_SRC-1:0]            src_en;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [DATA_W-1:0]             base;
  logic [1:0][VEC_W-1:0]         match;
  logic [1:0][DATA_W-1:0]        addr_lo;
  logic [1:0][HI_W-1:0]          addr_hi;
  logic [NUM_SRC-1:0]            pend;
  logic                          found;
  logic [VEC_W-1:0]              win_vec;
  logic [LVL_W-1:0]              win_lvl;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .src_en(src_en), .src_lvl(src_lvl), .base(base),
    .match(match), .addr_lo(addr_lo), .addr_hi(addr_hi)
  );

  irq_pending #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst_n(rst_sync_n),
    .req(irq_req), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .pend(pend)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .pend(pend), .src_en(src_en), .src_lvl(src_lvl), .core_mask(core_mask),
    .found(found), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  irq_vector_out #(.VEC_W(VEC_W)) u_vout (
    .clk(clk), .rst_n(rst_sync_n),
    .found(found), .win_vec(win_vec), .win_lvl(win_lvl),
    .base(base), .match(match), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .irq_fast(irq_fast), .irq_addr(irq_addr), .pres_level(pres_level)
  );

  // R4
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_valid |-> (irq_lvl >= $past(core_mask)));

  // R5
  winner_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_valid |-> ((($past(pend) >> irq_vec) & NUM_SRC'(1)) != '0));

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int NS = 16;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [15:0]   cfg_wdata;
  logic [NS-1:0] irq_req;
  logic [1:0]    core_mask;
  logic          ack_valid;
  logic [VW-1:0] ack_vec;
  logic          irq_valid;
  logic [VW-1:0] irq_vec;
  logic [1:0]    irq_lvl;
  logic          irq_fast;
  logic [20:0]   irq_addr;
  logic [1:0]    pres_level;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NS)) u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .core_mask(core_mask),
    .ack_valid(ack_valid), .ack_vec(ack_vec),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .irq_fast(irq_fast), .irq_addr(irq_addr), .pres_level(pres_level)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  logic          m_en  [NS];
  logic [1:0]    m_lvl [NS];
  logic [15:0]   m_base;
  logic [3:0]    m_match [2];
  logic [15:0]   m_lo [2];
  logic [4:0]    m_hi [2];
  logic [NS-1:0] m_pend;
  logic [1:0]    m_mask;

  // expected outputs
  logic          e_valid;
  logic [3:0]    e_vec;
  logic [1:0]    e_lvl;
  logic          e_fast;
  logic [20:0]   e_addr;
  logic [1:0]    e_stat;

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_wr(input logic [4:0] a, input logic [15:0] d);
    if (a < 5'd4) begin
      for (int k = 0; k < 4; k++) begin
        m_en[a*4+k]  = d[4*k+2];
        m_lvl[a*4+k] = d[4*k +: 2];
      end
    end else begin
      case (a)
        5'h10: m_base     = d;
        5'h11: m_match[0] = d[3:0];
        5'h12: m_match[1] = d[3:0];
        5'h13: m_lo[0]    = d;
        5'h14: m_hi[0]    = d[4:0];
        5'h15: m_lo[1]    = d;
        5'h16: m_hi[1]    = d[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic model_out();
    int sel;
    sel     = -1;
    e_valid = 0; e_vec = 0; e_lvl = 0; e_fast = 0; e_addr = 0; e_stat = 0;
    for (int l = 3; l >= 0 && sel < 0; l--) begin
      if (l >= int'(m_mask)) begin
        for (int i = 0; i < NS && sel < 0; i++)
          if (m_pend[i] && m_en[i] && int'(m_lvl[i]) == l) sel = i;
      end
    end
    if (sel >= 0) begin
      e_valid = 1;
      e_vec   = 4'(sel);
      e_lvl   = m_lvl[sel];
      e_stat  = (e_lvl == 0) ? 2'b01 : (e_lvl == 1) ? 2'b10 : 2'b11;
      if (e_lvl == 2 && m_match[0] == e_vec) begin
        e_fast = 1; e_addr = {m_hi[0], m_lo[0]};
      end else if (e_lvl == 2 && m_match[1] == e_vec) begin
        e_fast = 1; e_addr = {m_hi[1], m_lo[1]};
      end else begin
        e_addr = 21'(m_base * 32 + sel * 2);
      end
    end
  endtask

  task automatic cmp_all(input string rq);
    model_out();
    check(rq, "valid", 32'(irq_valid), 32'(e_valid));
    check(rq, "vec",   32'(irq_vec),   32'(e_vec));
    check(rq, "lvl",   32'(irq_lvl),   32'(e_lvl));
    check(rq, "fast",  32'(irq_fast),  32'(e_fast));
    check(rq, "addr",  32'(irq_addr),  32'(e_addr));
    check(rq, "stat",  32'(pres_level), 32'(e_stat));
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model_wr(a, d);
  endtask

  // one request/ack cycle, then settle two edges and sample
  task automatic step(input logic [NS-1:0] rq, input logic [1:0] mk,
                      input logic av, input logic [3:0] avec);
    @(negedge clk);
    irq_req = rq; core_mask = mk; ack_valid = av; ack_vec = avec;
    m_mask = mk;
    if (av) m_pend[avec] = 1'b0;
    m_pend = m_pend | rq;
    @(negedge clk);
    irq_req = '0; ack_valid = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
    m_base = 0; m_match[0] = 0; m_match[1] = 0;
    m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
    m_pend = '0; m_mask = 0;

    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    irq_req = 0; core_mask = 0; ack_valid = 0; ack_vec = 0;
    repeat (3) @(negedge clk);
    cmp_all("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_all("R1");

    // R2: disabled sources pending, nothing presented
    step(16'h00FF, 2'b00, 0, 0);
    cmp_all("R2");
    check("R11", "idle addr", 32'(irq_addr), 32'd0);
    // clear them
    for (int i = 0; i < 8; i++) step('0, 2'b00, 1, 4'(i));

    // sources 3,5 level1; 7 level0; base
    wr(5'h00, 16'h5000);          // src3 en lvl1
    wr(5'h01, 16'h4050);          // src5 en lvl1, src7 en lvl0
    wr(5'h10, 16'h0123);

    // R6 latency
    @(negedge clk);
    irq_req = 16'h00A8; m_pend = m_pend | 16'h00A8;
    @(negedge clk);
    irq_req = '0;
    check("R6", "valid one edge after request", 32'(irq_valid), 32'd0);
    @(negedge clk);
    check("R6", "valid two edges after request", 32'(irq_valid), 32'd1);

    // R5 tie at level 1: lowest vector 3
    step('0, 2'b00, 0, 0);
    cmp_all("R5");
    check("R5", "tie winner", 32'(irq_vec), 32'd3);
    check("R7", "status lvl1", 32'(pres_level), 32'b10);
    check("R8", "normal addr", 32'(irq_addr), 32'h0123 * 32 + 6);

    // R4 mask 10 hides level 1 and 0
    step('0, 2'b10, 0, 0);
    cmp_all("R4");
    check("R4", "masked valid", 32'(irq_valid), 32'd0);
    // mask 01 leaves level1
    step('0, 2'b01, 0, 0);
    cmp_all("R4");

    // R3 ack clears 3 -> 5 wins
    step('0, 2'b00, 1, 4'd3);
    cmp_all("R3");
    check("R3", "after ack", 32'(irq_vec), 32'd5);
    // R3 set wins over clear
    step(16'h0020, 2'b00, 1, 4'd5);
    cmp_all("R3");
    check("R3", "set beats clear", 32'(irq_vec), 32'd5);
    step('0, 2'b00, 1, 4'd5);
    step('0, 2'b00, 0, 0);
    check("R7", "status lvl0", 32'(pres_level), 32'b01);
    cmp_all("R7");

    // R9 fast: src9 level2
    wr(5'h02, 16'h0060);          // src9 en lvl2
    wr(5'h11, 16'h0009);
    wr(5'h13, 16'hBEEF);
    wr(5'h14, 16'h0015);
    wr(5'h12, 16'h0004);
    wr(5'h15, 16'h1234);
    wr(5'h16, 16'h000A);
    step(16'h0200, 2'b00, 0, 0);
    cmp_all("R9");
    check("R9", "fast addr", 32'(irq_addr), 32'h15BEEF);
    check("R9", "fast flag", 32'(irq_fast), 32'd1);
    check("R7", "status lvl2", 32'(pres_level), 32'b11);
    // level 3 with match -> normal
    wr(5'h02, 16'h0070);
    step('0, 2'b11, 0, 0);
    cmp_all("R9");
    check("R9", "lvl3 not fast", 32'(irq_fast), 32'd0);
    check("R4", "lvl3 under mask 11", 32'(irq_valid), 32'd1);
    // R10 both match registers equal
    wr(5'h02, 16'h0060);
    wr(5'h12, 16'h0009);
    step('0, 2'b00, 0, 0);
    cmp_all("R10");
    check("R10", "pair0 wins", 32'(irq_addr), 32'h15BEEF);
    wr(5'h11, 16'h000E);
    step('0, 2'b00, 0, 0);
    cmp_all("R10");
    check("R10", "pair1 used", 32'(irq_addr), 32'h0A1234);

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [NS-1:0] rq;
      logic [1:0]    mk;
      logic          av;
      logic [3:0]    avec;
      if (($urandom % 7) == 0) begin
        logic [4:0] a;
        logic [15:0] d;
        case ($urandom % 5)
          0, 1: a = 5'($urandom % 4);
          2:    a = 5'h11 + 5'($urandom % 2);
          3:    a = 5'h13 + 5'($urandom % 4);
          default: a = 5'h10;
        endcase
        d = 16'($urandom);
        wr(a, d);
      end
      rq   = NS'($urandom & $urandom & $urandom);
      mk   = 2'($urandom);
      av   = (($urandom % 3) == 0);
      avec = irq_valid ? irq_vec : 4'($urandom);
      step(rq, mk, av, avec);
      case (it % 4)
        0: cmp_all("R5");
        1: cmp_all("R4");
        2: cmp_all("R9");
        default: cmp_all("R3");
      endcase
    end

    summary();
    $finish;
  end

endmodule